// File: doc/BRIEF.md
# Partitioned Packed Register File

This block is a physical register file whose 64-bit entries are each cut into four 16-bit slices. A narrow result need not take a whole entry. It is stored in only the slices its 4-bit slice mask enables, so two or more narrow results can share one entry. The slices that hold one value may be non-adjacent, for example slices 3 and 0.

Every access names an entry index and a slice mask. On a write, the value is cut into 16-bit chunks from the least significant end. The chunks are scattered into the enabled slices, with the lowest enabled slice taking the lowest chunk. On a read, the enabled slices are collected in rising slice order and packed toward bit 0. The most significant bit of the top collected chunk is then copied into all unused upper bits.

There is one write port and two independent read ports. Each read result appears two clock edges after its request. Renaming, slice allocation and width detection are done outside this block.

Top module: `pkrf_top`

## Requirements
- R1: While `rst` is high, both read outputs are zero from the next rising edge on.
- R2: A write with `wr_en` high changes only the slices of entry `wr_idx` whose `wr_mask` bit is 1. The other slices of that entry and all other entries keep their contents.
- R3: On a write, chunk k of `wr_data` (bits 16k+15 down to 16k) goes to the slice at the k-th lowest set bit of `wr_mask`, counting from k = 0. Chunks beyond the number of set bits are discarded.
- R4: A read returns the enabled slices packed toward bit 0. The slice at the lowest set mask bit lands in bits 15:0, the next one in bits 31:16, and so on; a full mask 1111 returns the whole entry unchanged.
- R5: When fewer than four slices are read, every bit above the packed chunks equals bit 15 of the top packed chunk. For example, mask 1100 on a negative upper half returns a negative 64-bit value.
- R6: A read with mask 0000 returns zero.
- R7: Non-contiguous masks such as 1001 (slices 3 and 0) and 0101 store and return values as R3 and R4 define.
- R8: Two values written to the same entry under disjoint masks can both be read back later, each intact.
- R9: A read that names the entry and a slice written in the same cycle returns the newly written data for that slice.
- R10: Each read port returns the result of the index and mask presented two rising edges earlier. The two ports are independent of each other.
- R11: With `wr_en` low, nothing in the file changes, whatever `wr_idx`, `wr_mask` and `wr_data` carry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 5 | Write entry index |
| wr_mask | input | 4 | Write slice mask |
| wr_data | input | 64 | Write value, low chunks used |
| rd0_idx | input | 5 | Read port 0 entry index |
| rd0_mask | input | 4 | Read port 0 slice mask |
| rd1_idx | input | 5 | Read port 1 entry index |
| rd1_mask | input | 4 | Read port 1 slice mask |
| rd0_data | output | 64 | Read port 0 packed, sign-extended value |
| rd1_data | output | 64 | Read port 1 packed, sign-extended value |

## Verification
A write and a read can fall in the same cycle on the same entry. Their masks may overlap fully, partly or not at all. The bench provokes this on purpose, for example with a write under mask 0110 while port 0 reads mask 0011 of that entry. It also provokes it through a long random phase limited to a few entries so that collisions are frequent. The reference model applies the write first and then forms the read, per slice. The comparison two edges later therefore demands new data in the overlapping slices and old data elsewhere.

// File: rtl/pkrf_pkg.sv
package pkrf_pkg;
  parameter int unsigned PKRF_SLICES  = 4;
  parameter int unsigned PKRF_SLICE_W = 16;
  parameter int unsigned PKRF_ENTRIES = 32;

  // number of enabled slices in a mask
  function automatic int unsigned mask_count(input logic [31:0] m);
    int unsigned n;
    n = 0;
    for (int i = 0; i < 32; i++) n += int'(m[i]);
    return n;
  endfunction
endpackage

// File: rtl/pkrf_scatter.sv
module pkrf_scatter #(
  parameter int unsigned SLICES  = pkrf_pkg::PKRF_SLICES,
  parameter int unsigned SLICE_W = pkrf_pkg::PKRF_SLICE_W,
  localparam int unsigned DW     = SLICES * SLICE_W
) (
  input  logic [DW-1:0]     value,
  input  logic [SLICES-1:0] mask,
  output logic [DW-1:0]     slots
);
  always_comb begin
    int k;
    k = 0;
    slots = '0;
    for (int p = 0; p < SLICES; p++) begin
      if (mask[p]) begin
        slots[p*SLICE_W +: SLICE_W] = value[k*SLICE_W +: SLICE_W];
        k++;
      end
    end
  end
endmodule

// File: rtl/pkrf_gather.sv
module pkrf_gather #(
  parameter int unsigned SLICES  = pkrf_pkg::PKRF_SLICES,
  parameter int unsigned SLICE_W = pkrf_pkg::PKRF_SLICE_W,
  localparam int unsigned DW     = SLICES * SLICE_W
) (
  input  logic [DW-1:0]     slots,
  input  logic [SLICES-1:0] mask,
  output logic [DW-1:0]     value
);
  always_comb begin
    int  k;
    int  used;
    logic sgn;
    k = 0;
    value = '0;
    for (int p = 0; p < SLICES; p++) begin
      if (mask[p]) begin
        value[k*SLICE_W +: SLICE_W] = slots[p*SLICE_W +: SLICE_W];
        k++;
      end
    end
    used = int'(pkrf_pkg::mask_count(32'(mask))) * int'(SLICE_W);
    sgn  = (used == 0) ? 1'b0 : value[used-1];
    for (int b = 0; b < DW; b++) begin
      if (b >= used) value[b] = sgn;
    end
  end
endmodule

// File: rtl/pkrf_bank.sv
module pkrf_bank #(
  parameter int unsigned ENTRIES = pkrf_pkg::PKRF_ENTRIES,
  parameter int unsigned W       = pkrf_pkg::PKRF_SLICE_W,
  localparam int unsigned AW     = $clog2(ENTRIES)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] ra0,
  input  logic [AW-1:0] ra1,
  output logic [W-1:0]  rd0,
  output logic [W-1:0]  rd1
);
  logic [W-1:0] mem [ENTRIES];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  // synchronous reads, write-first on an address collision
  always_ff @(posedge clk) begin
    rd0 <= (we && waddr == ra0) ? wdata : mem[ra0];
    rd1 <= (we && waddr == ra1) ? wdata : mem[ra1];
  end
endmodule

// File: rtl/pkrf_top.sv
module pkrf_top #(
  parameter int unsigned ENTRIES = pkrf_pkg::PKRF_ENTRIES,
  parameter int unsigned SLICES  = pkrf_pkg::PKRF_SLICES,
  parameter int unsigned SLICE_W = pkrf_pkg::PKRF_SLICE_W,
  localparam int unsigned IDX_W  = $clog2(ENTRIES),
  localparam int unsigned DW     = SLICES * SLICE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [SLICES-1:0] wr_mask,
  input  logic [DW-1:0]     wr_data,
  input  logic [IDX_W-1:0]  rd0_idx,
  input  logic [SLICES-1:0] rd0_mask,
  input  logic [IDX_W-1:0]  rd1_idx,
  input  logic [SLICES-1:0] rd1_mask,
  output logic [DW-1:0]     rd0_data,
  output logic [DW-1:0]     rd1_data
);
  logic [DW-1:0]     wr_slots;
  logic [DW-1:0]     s0_slots, s1_slots;
  logic [SLICES-1:0] m0_q, m1_q;
  logic [DW-1:0]     g0, g1;

  pkrf_scatter #(.SLICES(SLICES), .SLICE_W(SLICE_W)) u_scatter (
    .value(wr_data), .mask(wr_mask), .slots(wr_slots)
  );

  for (genvar p = 0; p < SLICES; p++) begin : g_slice
    pkrf_bank #(.ENTRIES(ENTRIES), .W(SLICE_W)) u_bank (
      .clk  (clk),
      .we   (wr_en & wr_mask[p]),
      .waddr(wr_idx),
      .wdata(wr_slots[p*SLICE_W +: SLICE_W]),
      .ra0  (rd0_idx),
      .ra1  (rd1_idx),
      .rd0  (s0_slots[p*SLICE_W +: SLICE_W]),
      .rd1  (s1_slots[p*SLICE_W +: SLICE_W])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      m0_q <= '0;
      m1_q <= '0;
    end else begin
      m0_q <= rd0_mask;
      m1_q <= rd1_mask;
    end
  end

  pkrf_gather #(.SLICES(SLICES), .SLICE_W(SLICE_W)) u_gather0 (
    .slots(s0_slots), .mask(m0_q), .value(g0)
  );
  pkrf_gather #(.SLICES(SLICES), .SLICE_W(SLICE_W)) u_gather1 (
    .slots(s1_slots), .mask(m1_q), .value(g1)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd0_data <= '0;
      rd1_data <= '0;
    end else begin
      rd0_data <= g0;
      rd1_data <= g1;
    end
  end
endmodule

// File: rtl/pkrf_chk.sv
module pkrf_chk #(
  parameter int unsigned IDX_W   = 5,
  parameter int unsigned SLICES  = 4,
  parameter int unsigned SLICE_W = 16,
  localparam int unsigned DW     = SLICES * SLICE_W
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [IDX_W-1:0]  wr_idx,
  input logic [SLICES-1:0] wr_mask,
  input logic [DW-1:0]     wr_data,
  input logic [IDX_W-1:0]  rd0_idx,
  input logic [SLICES-1:0] rd0_mask,
  input logic [IDX_W-1:0]  rd1_idx,
  input logic [SLICES-1:0] rd1_mask,
  input logic [DW-1:0]     rd0_data,
  input logic [DW-1:0]     rd1_data
);
  // R1
  reset_clears_chk: assert property (@(posedge clk)
    rst |=> (rd0_data == '0 && rd1_data == '0));

  // R6
  empty_mask_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (rd1_mask == '0) |=> ##1 (rd1_data == '0));

  // R5
  single_slice_sext_chk: assert property (@(posedge clk) disable iff (rst)
    ($countones(rd0_mask) == 1) |=> ##1
      (rd0_data[DW-1:SLICE_W] == {(DW-SLICE_W){rd0_data[SLICE_W-1]}}));

  // R9
  full_forward_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_mask == '1 && rd0_mask == '1 && rd0_idx == wr_idx)
      |=> ##1 (rd0_data == $past(wr_data, 2)));

  // R10
  ports_agree_chk: assert property (@(posedge clk) disable iff (rst)
    (rd0_idx == rd1_idx && rd0_mask == rd1_mask) |=> ##1 (rd0_data == rd1_data));
endmodule

bind pkrf_top pkrf_chk #(.IDX_W(IDX_W), .SLICES(SLICES), .SLICE_W(SLICE_W)) i_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_mask(wr_mask),
  .wr_data(wr_data), .rd0_idx(rd0_idx), .rd0_mask(rd0_mask), .rd1_idx(rd1_idx),
  .rd1_mask(rd1_mask), .rd0_data(rd0_data), .rd1_data(rd1_data)
);

// File: tb/test_pkrf_top.sv
module test_pkrf_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [4:0]  wr_idx = '0;
  logic [3:0]  wr_mask = '0;
  logic [63:0] wr_data = '0;
  logic [4:0]  rd0_idx = '0, rd1_idx = '0;
  logic [3:0]  rd0_mask = '0, rd1_mask = '0;
  logic [63:0] rd0_data, rd1_data;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [15:0] model [32][4];
  logic [63:0] q0[$], q1[$];
  string       qt[$];

  always #4 clk = ~clk;

  pkrf_top i_pkrf_top (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_mask(wr_mask),
    .wr_data(wr_data), .rd0_idx(rd0_idx), .rd0_mask(rd0_mask),
    .rd1_idx(rd1_idx), .rd1_mask(rd1_mask), .rd0_data(rd0_data), .rd1_data(rd1_data)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic void model_write(input int e, input logic [3:0] m, input logic [63:0] d);
    logic [63:0] rest;
    rest = d;
    for (int p = 0; p < 4; p++) begin
      if (m[p]) begin
        model[e][p] = rest[15:0];
        rest = rest >> 16;
      end
    end
  endfunction

  function automatic logic [63:0] model_read(input int e, input logic [3:0] m);
    logic [15:0] chunks[$];
    logic signed [63:0] v;
    int n;
    for (int p = 0; p < 4; p++) if (m[p]) chunks.push_back(model[e][p]);
    n = chunks.size();
    if (n == 0) return 64'd0;
    v = '0;
    for (int i = n - 1; i >= 0; i--) v = (v << 16) | 64'(chunks[i]);
    v = v <<< (64 - 16 * n);
    v = v >>> (64 - 16 * n);
    return v;
  endfunction

  task automatic cyc(input logic we, input int wi, input logic [3:0] wm,
                     input logic [63:0] wd, input int a, input logic [3:0] am,
                     input int b, input logic [3:0] bm, input string tag);
    wr_en = we; wr_idx = 5'(wi); wr_mask = wm; wr_data = wd;
    rd0_idx = 5'(a); rd0_mask = am; rd1_idx = 5'(b); rd1_mask = bm;
    if (we) model_write(wi, wm, wd);
    q0.push_back(model_read(a, am));
    q1.push_back(model_read(b, bm));
    qt.push_back(tag);
    @(posedge clk);
    @(negedge clk);
    if (q0.size() >= 2) begin
      string t;
      t = qt.pop_front();
      check({t, " port0"}, rd0_data, q0.pop_front());
      check({t, " port1"}, rd1_data, q1.pop_front());
    end
  endtask

  task automatic idle(input string tag);
    cyc(1'b0, 0, 4'h0, 64'd0, 0, 4'h0, 0, 4'h0, tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual running expected finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    // R1: outputs cleared during reset
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 rd0", rd0_data, 64'd0);
    check("R1 rd1", rd1_data, 64'd0);
    rst = 1'b0;

    for (int e = 0; e < 32; e++) cyc(1'b1, e, 4'hF, 64'd0, 0, 4'h0, 0, 4'h0, "R6 init");

    // R4: full width round trip, R10 other port independent
    cyc(1'b1, 5, 4'hF, 64'h8123_4567_89AB_CDEF, 0, 4'h0, 1, 4'h0, "R2 full write");
    cyc(1'b0, 0, 4'h0, 64'd0, 5, 4'hF, 1, 4'h3, "R4 full read");
    // R7/R8: two values share entry 7
    cyc(1'b1, 7, 4'b1001, 64'h0000_0000_0000_8001, 0, 4'h0, 0, 4'h0, "R7 write 1001");
    cyc(1'b1, 7, 4'b0110, 64'hFFFF_FFFF_FFFF_1234, 0, 4'h0, 0, 4'h0, "R8 write 0110");
    cyc(1'b0, 0, 4'h0, 64'd0, 7, 4'b1001, 7, 4'b0110, "R8 both values");
    cyc(1'b0, 0, 4'h0, 64'd0, 7, 4'hF, 7, 4'b0101, "R7 mixed masks");
    // R5: upper half negative
    cyc(1'b1, 9, 4'b1100, 64'h0000_0000_F00D_BEEF, 0, 4'h0, 0, 4'h0, "R5 write 1100");
    cyc(1'b0, 0, 4'h0, 64'd0, 9, 4'b1100, 9, 4'b1000, "R5 sign fill");
    cyc(1'b0, 0, 4'h0, 64'd0, 9, 4'hF, 9, 4'b0100, "R2 lower intact");
    // R3: surplus chunks dropped
    cyc(1'b1, 11, 4'b0010, 64'hAAAA_BBBB_CCCC_7777, 0, 4'h0, 0, 4'h0, "R3 write 0010");
    cyc(1'b0, 0, 4'h0, 64'd0, 11, 4'b0010, 11, 4'hF, "R3 one chunk");
    // R6: zero mask
    cyc(1'b0, 0, 4'h0, 64'd0, 5, 4'h0, 7, 4'h0, "R6 zero mask");
    // R11: disabled write
    cyc(1'b0, 5, 4'hF, 64'h1111_2222_3333_4444, 0, 4'h0, 0, 4'h0, "R11 disabled");
    cyc(1'b0, 0, 4'h0, 64'd0, 5, 4'hF, 5, 4'h1, "R11 unchanged");
    // R9: same-cycle collision, partial overlap
    cyc(1'b1, 7, 4'b0110, 64'h0000_0000_5555_6666, 7, 4'b0011, 7, 4'b1111, "R9 forward");
    cyc(1'b1, 3, 4'hF, 64'hDEAD_BEEF_0BAD_F00D, 3, 4'hF, 3, 4'b1010, "R9 full forward");
    // R10: random phase with frequent collisions
    for (int i = 0; i < 400; i++) begin
      logic [63:0] d;
      d = {$urandom, $urandom};
      cyc(1'($urandom), int'($urandom % 4), 4'($urandom), d,
          int'($urandom % 4), 4'($urandom), int'($urandom % 4), 4'($urandom), "R10 random");
    end
    idle("R10 drain");
    idle("R10 drain");
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule